// File: doc/BRIEF.md
# Shader Bundle Issue Unit

This block sits in front of one shader ALU made of four multiply-add lanes and a single multi-function unit. Each clock it may accept one instruction bundle. The bundle holds up to four lane operations and one optional multi-function operation. The block works out how many lanes each operation needs, places the operations onto the lanes, and checks that the result is one of the four legal operation mixes. It then sends opcodes and register indices to each lane and to the multi-function unit. Dot-product operations take two or three neighbouring lanes. The block links those lanes with a chain flag so the lanes can combine their products.

Lane operations are placed in slot order, skipping slots whose valid bit is clear. Each operation starts at the first free lane. The lane that handles element e of a dot product reads sources A and B at the operation's base index plus e. It reads source C (the accumulator) and the destination unchanged. A rejected bundle raises an error pulse and issues nothing. All outputs are registered. A stall input freezes them.

Top module: `shader_bundle_issue`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears to zero.
- R2: Outputs reflect the bundle accepted at the previous rising edge. An edge with `in_vld` low and `stall` low leaves no lane, multi-function or error output set in the next cycle.
- R3: Lane kinds are 0 = multiply-add (one lane), 1 = two-element dot-product-accumulate (two lanes), 2 = three-element dot-product-accumulate (three lanes) and 3 = reserved. Four multiply-adds with no multi-function operation are legal. They issue to lanes 0..3 in slot order with kind 0 and no chain flags.
- R4: Two two-element dot products plus a multi-function operation are legal. They occupy lanes 0-1 and 2-3. Chain is set on lanes 0 and 2. Lane e of each operation reads A+e and B+e.
- R5: One three-element dot product followed by one multiply-add plus a multi-function operation is legal. The dot product must be the first lane operation and takes lanes 0-2, with chain on lanes 0 and 1. The multiply-add takes lane 3. The reverse order is illegal.
- R6: One two-element dot product and two multiply-adds plus a multi-function operation are legal only when the dot product starts at an even lane (lane 0 or 2). A start at lane 1 is illegal.
- R7: Multi-function codes are 3 bits: 0 log, 1 exp, 2 sin/cos, 3 reciprocal, 4 square root, 5 move. Codes 6 and 7 make the bundle illegal. On issue, the code, source and destination pass through unchanged.
- R8: A valid bundle that is not one of the legal mixes sets `bad_bundle` for one cycle and issues no lane and no multi-function operation. Illegal mixes include a reserved kind, more than four lanes of demand, a missing or extra multi-function operation, and an empty bundle.
- R9: While `stall` is high, every output holds its value and the input bundle is ignored.
- R10: A legal issue always fills all four lanes. The chain flag is set on every dot-product lane except the last one of its operation, and never on a multiply-add lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Bundle present this cycle |
| stall | input | 1 | Freeze outputs, ignore bundle |
| op_vld | input | NUM_OPS | Valid bit per lane-operation slot |
| op_kind | input | 2*NUM_OPS | Kind per slot (slot i at bits 2i+1:2i) |
| op_src_a | input | NUM_OPS*IDX_W | Source A base index per slot |
| op_src_b | input | NUM_OPS*IDX_W | Source B base index per slot |
| op_src_c | input | NUM_OPS*IDX_W | Accumulator index per slot |
| op_dst | input | NUM_OPS*IDX_W | Destination index per slot |
| mfu_vld | input | 1 | Multi-function operation present |
| mfu_op | input | 3 | Multi-function code |
| mfu_src | input | IDX_W | Multi-function source index |
| mfu_dst | input | IDX_W | Multi-function destination index |
| lane_vld | output | NUM_LANES | Lane issued |
| lane_chain | output | NUM_LANES | Lane feeds its sum into the next lane |
| lane_kind | output | 2*NUM_LANES | Kind of the operation on each lane |
| lane_src_a | output | NUM_LANES*IDX_W | Per-lane source A index |
| lane_src_b | output | NUM_LANES*IDX_W | Per-lane source B index |
| lane_src_c | output | NUM_LANES*IDX_W | Per-lane accumulator index |
| lane_dst | output | NUM_LANES*IDX_W | Per-lane destination index |
| mfu_issue | output | 1 | Multi-function operation issued |
| mfu_code | output | 3 | Issued multi-function code |
| mfu_src_o | output | IDX_W | Issued multi-function source |
| mfu_dst_o | output | IDX_W | Issued multi-function destination |
| bad_bundle | output | 1 | Illegal bundle seen |

## Verification
The assertions check several properties on every cycle. An error cycle issues nothing. Issued lanes always come as a full set of four. A chain flag always points at a valid lane of the same dot-product kind, and the last lane never chains. Issued multi-function codes stay in 0..5. A stall freezes all outputs, and an idle cycle clears them. Other properties can only be shown by the bench's scenarios. These include the exact lane placement and the A+e / B+e index offsets of each legal mix, and the rejection of mixes with the right lane count but the wrong order or alignment. They also include the pass-through of operand fields and the recovery from an error pulse.

// File: rtl/shader_issue_pkg.sv
package shader_issue_pkg;

  typedef enum logic [1:0] {
    KIND_MAD = 2'd0,
    KIND_DP2 = 2'd1,
    KIND_DP3 = 2'd2,
    KIND_RSV = 2'd3
  } op_kind_e;

  localparam int MFU_CODE_W = 3;
  localparam logic [MFU_CODE_W-1:0] MFU_CODE_MAX = 3'd5;

  // Lanes consumed by one operation of a given kind; 0 flags a reserved kind.
  function automatic logic [1:0] kind_lanes(op_kind_e k);
    case (k)
      KIND_MAD: kind_lanes = 2'd1;
      KIND_DP2: kind_lanes = 2'd2;
      KIND_DP3: kind_lanes = 2'd3;
      default:  kind_lanes = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bundle_place.sv
module bundle_place
  import shader_issue_pkg::*;
#(
  parameter int NUM_OPS   = 4,
  parameter int NUM_LANES = 4,
  parameter int CUR_W     = 4
) (
  input  logic [NUM_OPS-1:0]       op_vld,
  input  logic [2*NUM_OPS-1:0]     op_kind,
  input  logic                     mfu_present,
  output logic [NUM_OPS*CUR_W-1:0] op_start,
  output logic [2*NUM_OPS-1:0]     op_lanes,
  output logic                     mix_ok
);

  localparam int CNT_W = $clog2(NUM_OPS + 1);

  logic [CUR_W-1:0] cursor;
  logic [CNT_W-1:0] n_mad, n_dp2, n_dp3;
  logic             misaligned, reserved_seen;
  logic             count_match;

  // Walk the slots in order, handing each valid operation the next free lane.
  always_comb begin
    cursor        = '0;
    n_mad         = '0;
    n_dp2         = '0;
    n_dp3         = '0;
    misaligned    = 1'b0;
    reserved_seen = 1'b0;
    op_start      = '0;
    op_lanes      = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      if (op_vld[i]) begin
        op_start[i*CUR_W +: CUR_W] = cursor;
        op_lanes[2*i +: 2]         = kind_lanes(op_kind_e'(op_kind[2*i +: 2]));
        case (op_kind_e'(op_kind[2*i +: 2]))
          KIND_MAD: n_mad = n_mad + CNT_W'(1);
          KIND_DP2: begin
            n_dp2 = n_dp2 + CNT_W'(1);
            if (cursor[0]) misaligned = 1'b1;
          end
          KIND_DP3: begin
            n_dp3 = n_dp3 + CNT_W'(1);
            if (cursor != '0) misaligned = 1'b1;
          end
          default: reserved_seen = 1'b1;
        endcase
        cursor = cursor + CUR_W'(kind_lanes(op_kind_e'(op_kind[2*i +: 2])));
      end
    end
  end

  // The four permitted operation mixes.
  always_comb begin
    count_match =
      (!mfu_present && n_mad == CNT_W'(4) && n_dp2 == '0 && n_dp3 == '0) ||
      ( mfu_present && n_mad == '0 && n_dp2 == CNT_W'(2) && n_dp3 == '0) ||
      ( mfu_present && n_mad == CNT_W'(1) && n_dp2 == '0 && n_dp3 == CNT_W'(1)) ||
      ( mfu_present && n_mad == CNT_W'(2) && n_dp2 == CNT_W'(1) && n_dp3 == '0);
  end

  assign mix_ok = count_match && !misaligned && !reserved_seen &&
                  (cursor == CUR_W'(NUM_LANES));

endmodule

// File: rtl/lane_steer.sv
module lane_steer
  import shader_issue_pkg::*;
#(
  parameter int NUM_OPS   = 4,
  parameter int NUM_LANES = 4,
  parameter int IDX_W     = 6,
  parameter int CUR_W     = 4
) (
  input  logic [NUM_OPS-1:0]         op_vld,
  input  logic [2*NUM_OPS-1:0]       op_kind,
  input  logic [NUM_OPS*IDX_W-1:0]   op_src_a,
  input  logic [NUM_OPS*IDX_W-1:0]   op_src_b,
  input  logic [NUM_OPS*IDX_W-1:0]   op_src_c,
  input  logic [NUM_OPS*IDX_W-1:0]   op_dst,
  input  logic [NUM_OPS*CUR_W-1:0]   op_start,
  input  logic [2*NUM_OPS-1:0]       op_lanes,
  output logic [NUM_LANES-1:0]       s_vld,
  output logic [NUM_LANES-1:0]       s_chain,
  output logic [2*NUM_LANES-1:0]     s_kind,
  output logic [NUM_LANES*IDX_W-1:0] s_src_a,
  output logic [NUM_LANES*IDX_W-1:0] s_src_b,
  output logic [NUM_LANES*IDX_W-1:0] s_src_c,
  output logic [NUM_LANES*IDX_W-1:0] s_dst
);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [CUR_W-1:0] st, span, elem;
    localparam logic [CUR_W-1:0] LANE_ID = CUR_W'(l);

    // Find the operation whose lane range covers this lane.
    always_comb begin
      s_vld[l]                  = 1'b0;
      s_chain[l]                = 1'b0;
      s_kind[2*l +: 2]          = '0;
      s_src_a[l*IDX_W +: IDX_W] = '0;
      s_src_b[l*IDX_W +: IDX_W] = '0;
      s_src_c[l*IDX_W +: IDX_W] = '0;
      s_dst[l*IDX_W +: IDX_W]   = '0;
      st   = '0;
      span = '0;
      elem = '0;
      for (int i = 0; i < NUM_OPS; i++) begin
        st   = op_start[i*CUR_W +: CUR_W];
        span = {{(CUR_W-2){1'b0}}, op_lanes[2*i +: 2]};
        if (op_vld[i] && LANE_ID >= st && LANE_ID < st + span) begin
          elem                      = LANE_ID - st;
          s_vld[l]                  = 1'b1;
          s_chain[l]                = (elem != span - CUR_W'(1));
          s_kind[2*l +: 2]          = op_kind[2*i +: 2];
          s_src_a[l*IDX_W +: IDX_W] = op_src_a[i*IDX_W +: IDX_W] + IDX_W'(elem);
          s_src_b[l*IDX_W +: IDX_W] = op_src_b[i*IDX_W +: IDX_W] + IDX_W'(elem);
          s_src_c[l*IDX_W +: IDX_W] = op_src_c[i*IDX_W +: IDX_W];
          s_dst[l*IDX_W +: IDX_W]   = op_dst[i*IDX_W +: IDX_W];
        end
      end
    end
  end

endmodule

// File: rtl/mfu_gate.sv
module mfu_gate
  import shader_issue_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                  mfu_vld,
  input  logic [MFU_CODE_W-1:0] mfu_op,
  input  logic [IDX_W-1:0]      mfu_src,
  input  logic [IDX_W-1:0]      mfu_dst,
  output logic                  code_ok,
  output logic [MFU_CODE_W-1:0] g_code,
  output logic [IDX_W-1:0]      g_src,
  output logic [IDX_W-1:0]      g_dst
);

  // Codes above the last defined function are rejected.
  assign code_ok = !mfu_vld || (mfu_op <= MFU_CODE_MAX);
  assign g_code  = mfu_vld ? mfu_op  : '0;
  assign g_src   = mfu_vld ? mfu_src : '0;
  assign g_dst   = mfu_vld ? mfu_dst : '0;

endmodule

// File: rtl/shader_bundle_issue.sv
module shader_bundle_issue
  import shader_issue_pkg::*;
#(
  parameter int NUM_OPS   = 4,
  parameter int NUM_LANES = 4,
  parameter int IDX_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_vld,
  input  logic                       stall,
  input  logic [NUM_OPS-1:0]         op_vld,
  input  logic [2*NUM_OPS-1:0]       op_kind,
  input  logic [NUM_OPS*IDX_W-1:0]   op_src_a,
  input  logic [NUM_OPS*IDX_W-1:0]   op_src_b,
  input  logic [NUM_OPS*IDX_W-1:0]   op_src_c,
  input  logic [NUM_OPS*IDX_W-1:0]   op_dst,
  input  logic                       mfu_vld,
  input  logic [2:0]                 mfu_op,
  input  logic [IDX_W-1:0]           mfu_src,
  input  logic [IDX_W-1:0]           mfu_dst,
  output logic [NUM_LANES-1:0]       lane_vld,
  output logic [NUM_LANES-1:0]       lane_chain,
  output logic [2*NUM_LANES-1:0]     lane_kind,
  output logic [NUM_LANES*IDX_W-1:0] lane_src_a,
  output logic [NUM_LANES*IDX_W-1:0] lane_src_b,
  output logic [NUM_LANES*IDX_W-1:0] lane_src_c,
  output logic [NUM_LANES*IDX_W-1:0] lane_dst,
  output logic                       mfu_issue,
  output logic [2:0]                 mfu_code,
  output logic [IDX_W-1:0]           mfu_src_o,
  output logic [IDX_W-1:0]           mfu_dst_o,
  output logic                       bad_bundle
);

  localparam int CUR_W = $clog2(NUM_OPS * 3 + 1);

  logic [NUM_OPS*CUR_W-1:0]   op_start;
  logic [2*NUM_OPS-1:0]       op_lanes;
  logic                       mix_ok, code_ok, bundle_ok;
  logic [NUM_LANES-1:0]       s_vld, s_chain;
  logic [2*NUM_LANES-1:0]     s_kind;
  logic [NUM_LANES*IDX_W-1:0] s_src_a, s_src_b, s_src_c, s_dst;
  logic [MFU_CODE_W-1:0]      g_code;
  logic [IDX_W-1:0]           g_src, g_dst;

  bundle_place #(
    .NUM_OPS(NUM_OPS), .NUM_LANES(NUM_LANES), .CUR_W(CUR_W)
  ) u_place (
    .op_vld     (op_vld),
    .op_kind    (op_kind),
    .mfu_present(mfu_vld),
    .op_start   (op_start),
    .op_lanes   (op_lanes),
    .mix_ok     (mix_ok)
  );

  lane_steer #(
    .NUM_OPS(NUM_OPS), .NUM_LANES(NUM_LANES), .IDX_W(IDX_W), .CUR_W(CUR_W)
  ) u_steer (
    .op_vld  (op_vld),
    .op_kind (op_kind),
    .op_src_a(op_src_a),
    .op_src_b(op_src_b),
    .op_src_c(op_src_c),
    .op_dst  (op_dst),
    .op_start(op_start),
    .op_lanes(op_lanes),
    .s_vld   (s_vld),
    .s_chain (s_chain),
    .s_kind  (s_kind),
    .s_src_a (s_src_a),
    .s_src_b (s_src_b),
    .s_src_c (s_src_c),
    .s_dst   (s_dst)
  );

  mfu_gate #(.IDX_W(IDX_W)) u_mfu (
    .mfu_vld(mfu_vld),
    .mfu_op (mfu_op),
    .mfu_src(mfu_src),
    .mfu_dst(mfu_dst),
    .code_ok(code_ok),
    .g_code (g_code),
    .g_src  (g_src),
    .g_dst  (g_dst)
  );

  assign bundle_ok = mix_ok && code_ok;

  // Issue register stage: one cycle of latency, frozen by stall.
  always_ff @(posedge clk) begin
    if (rst) begin
      lane_vld   <= '0;
      lane_chain <= '0;
      lane_kind  <= '0;
      lane_src_a <= '0;
      lane_src_b <= '0;
      lane_src_c <= '0;
      lane_dst   <= '0;
      mfu_issue  <= 1'b0;
      mfu_code   <= '0;
      mfu_src_o  <= '0;
      mfu_dst_o  <= '0;
      bad_bundle <= 1'b0;
    end else if (!stall) begin
      if (in_vld && bundle_ok) begin
        lane_vld   <= s_vld;
        lane_chain <= s_chain;
        lane_kind  <= s_kind;
        lane_src_a <= s_src_a;
        lane_src_b <= s_src_b;
        lane_src_c <= s_src_c;
        lane_dst   <= s_dst;
        mfu_issue  <= mfu_vld;
        mfu_code   <= g_code;
        mfu_src_o  <= g_src;
        mfu_dst_o  <= g_dst;
        bad_bundle <= 1'b0;
      end else begin
        lane_vld   <= '0;
        lane_chain <= '0;
        lane_kind  <= '0;
        lane_src_a <= '0;
        lane_src_b <= '0;
        lane_src_c <= '0;
        lane_dst   <= '0;
        mfu_issue  <= 1'b0;
        mfu_code   <= '0;
        mfu_src_o  <= '0;
        mfu_dst_o  <= '0;
        bad_bundle <= in_vld;
      end
    end
  end

  // Guards on the issue stage.
  p_bad_silent_r8: assert property (@(posedge clk) disable iff (rst)
    bad_bundle |-> (lane_vld == '0) && !mfu_issue);

  p_full_issue_r10: assert property (@(posedge clk) disable iff (rst)
    (|lane_vld) |-> (&lane_vld));

  p_last_unchained_r10: assert property (@(posedge clk) disable iff (rst)
    !lane_chain[NUM_LANES-1]);

  for (genvar l = 0; l < NUM_LANES - 1; l++) begin : g_chain_chk
    p_chain_link_r10: assert property (@(posedge clk) disable iff (rst)
      lane_chain[l] |-> lane_vld[l+1] &&
                        (lane_kind[2*l +: 2] != KIND_MAD) &&
                        (lane_kind[2*(l+1) +: 2] == lane_kind[2*l +: 2]));
  end

  p_mfu_code_r7: assert property (@(posedge clk) disable iff (rst)
    mfu_issue |-> (mfu_code <= MFU_CODE_MAX));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable({lane_vld, lane_chain, lane_kind, lane_src_a, lane_src_b,
                       lane_src_c, lane_dst, mfu_issue, mfu_code, mfu_src_o,
                       mfu_dst_o, bad_bundle}));

  p_idle_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !stall) |=> (lane_vld == '0) && !mfu_issue && !bad_bundle);

endmodule

// File: tb/shader_bundle_issue_tb.sv
module shader_bundle_issue_tb;

  localparam int NOPS = 4;
  localparam int NL   = 4;
  localparam int IW   = 6;
  localparam int OUTW = NL + NL + 2*NL + 4*NL*IW + 1 + 3 + IW + IW + 1;

  localparam logic [1:0] KM = 2'd0, KD2 = 2'd1, KD3 = 2'd2, KR = 2'd3;

  logic clk = 1'b0;
  logic rst;
  logic in_vld, stall;
  logic [NOPS-1:0]    op_vld;
  logic [2*NOPS-1:0]  op_kind;
  logic [NOPS*IW-1:0] op_src_a, op_src_b, op_src_c, op_dst;
  logic               mfu_vld;
  logic [2:0]         mfu_op;
  logic [IW-1:0]      mfu_src, mfu_dst;
  logic [NL-1:0]      lane_vld, lane_chain;
  logic [2*NL-1:0]    lane_kind;
  logic [NL*IW-1:0]   lane_src_a, lane_src_b, lane_src_c, lane_dst;
  logic               mfu_issue;
  logic [2:0]         mfu_code;
  logic [IW-1:0]      mfu_src_o, mfu_dst_o;
  logic               bad_bundle;

  logic [OUTW-1:0] expv;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  shader_bundle_issue #(.NUM_OPS(NOPS), .NUM_LANES(NL), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .stall(stall),
    .op_vld(op_vld), .op_kind(op_kind),
    .op_src_a(op_src_a), .op_src_b(op_src_b), .op_src_c(op_src_c), .op_dst(op_dst),
    .mfu_vld(mfu_vld), .mfu_op(mfu_op), .mfu_src(mfu_src), .mfu_dst(mfu_dst),
    .lane_vld(lane_vld), .lane_chain(lane_chain), .lane_kind(lane_kind),
    .lane_src_a(lane_src_a), .lane_src_b(lane_src_b), .lane_src_c(lane_src_c),
    .lane_dst(lane_dst), .mfu_issue(mfu_issue), .mfu_code(mfu_code),
    .mfu_src_o(mfu_src_o), .mfu_dst_o(mfu_dst_o), .bad_bundle(bad_bundle)
  );

  // Reference: legality by matching the ordered kind sequence, then lane walk.
  function automatic logic [OUTW-1:0] predict();
    logic [1:0]       seq [NOPS];
    int               n;
    bit               legal;
    int               lane;
    int               w;
    logic [NL-1:0]    e_vld, e_chain;
    logic [2*NL-1:0]  e_kind;
    logic [NL*IW-1:0] e_a, e_b, e_c, e_d;
    e_vld = '0; e_chain = '0; e_kind = '0;
    e_a = '0; e_b = '0; e_c = '0; e_d = '0;
    n = 0;
    for (int i = 0; i < NOPS; i++) seq[i] = 2'd0;
    for (int i = 0; i < NOPS; i++)
      if (op_vld[i]) begin seq[n] = op_kind[2*i +: 2]; n++; end
    if (!mfu_vld)
      legal = (n == 4) && seq[0] == KM && seq[1] == KM && seq[2] == KM && seq[3] == KM;
    else if (mfu_op > 3'd5)
      legal = 0;
    else if (n == 2)
      legal = (seq[0] == KD2 && seq[1] == KD2) || (seq[0] == KD3 && seq[1] == KM);
    else if (n == 3)
      legal = (seq[0] == KD2 && seq[1] == KM && seq[2] == KM) ||
              (seq[0] == KM && seq[1] == KM && seq[2] == KD2);
    else
      legal = 0;
    if (!in_vld) return '0;
    if (!legal) return {{(OUTW-1){1'b0}}, 1'b1};
    lane = 0;
    for (int i = 0; i < NOPS; i++) begin
      if (op_vld[i]) begin
        w = (op_kind[2*i +: 2] == KM) ? 1 : (op_kind[2*i +: 2] == KD2) ? 2 : 3;
        for (int e = 0; e < w; e++) begin
          e_vld[lane]            = 1'b1;
          e_chain[lane]          = (e < w - 1);
          e_kind[2*lane +: 2]    = op_kind[2*i +: 2];
          e_a[lane*IW +: IW]     = op_src_a[i*IW +: IW] + IW'(e);
          e_b[lane*IW +: IW]     = op_src_b[i*IW +: IW] + IW'(e);
          e_c[lane*IW +: IW]     = op_src_c[i*IW +: IW];
          e_d[lane*IW +: IW]     = op_dst[i*IW +: IW];
          lane++;
        end
      end
    end
    return {e_vld, e_chain, e_kind, e_a, e_b, e_c, e_d,
            mfu_vld, mfu_op, mfu_src, mfu_dst, 1'b0};
  endfunction

  task automatic clear_bundle();
    in_vld = 0; op_vld = '0; op_kind = '0;
    op_src_a = '0; op_src_b = '0; op_src_c = '0; op_dst = '0;
    mfu_vld = 0; mfu_op = '0; mfu_src = '0; mfu_dst = '0;
  endtask

  task automatic set_op(int i, logic [1:0] k);
    op_vld[i]          = 1'b1;
    op_kind[2*i +: 2]  = k;
    op_src_a[i*IW +: IW] = IW'(8*i + 1);
    op_src_b[i*IW +: IW] = IW'(8*i + 3);
    op_src_c[i*IW +: IW] = IW'(8*i + 5);
    op_dst[i*IW +: IW]   = IW'(8*i + 7);
  endtask

  task automatic set_mfu(logic [2:0] code);
    mfu_vld = 1; mfu_op = code; mfu_src = 6'd41; mfu_dst = 6'd42;
  endtask

  // Drive at the falling edge, sample just after the next rising edge.
  task automatic step(string tag);
    logic [OUTW-1:0] act;
    @(negedge clk);
    if (rst) expv = '0;
    else if (!stall) expv = predict();
    @(posedge clk);
    #1;
    act = {lane_vld, lane_chain, lane_kind, lane_src_a, lane_src_b, lane_src_c,
           lane_dst, mfu_issue, mfu_code, mfu_src_o, mfu_dst_o, bad_bundle};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic random_bundle();
    int sel;
    clear_bundle();
    in_vld = ($urandom % 8) != 0;
    sel = $urandom % 6;
    case (sel)
      0: for (int i = 0; i < 4; i++) set_op(i, KM);
      1: begin set_op(0, KD2); set_op(1, KD2); set_mfu(3'($urandom % 6)); end
      2: begin set_op(0, KD3); set_op(1, KM); set_mfu(3'($urandom % 8)); end
      3: begin set_op(0, KM); set_op(1, KM); set_op(2, KD2); set_mfu(3'($urandom % 6)); end
      default: begin
        for (int i = 0; i < NOPS; i++)
          if ($urandom % 2) set_op(i, 2'($urandom % 4));
        if ($urandom % 2) set_mfu(3'($urandom % 8));
      end
    endcase
    op_src_a = NOPS*IW'($urandom);
    op_src_b = NOPS*IW'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; stall = 0; expv = '0;
    clear_bundle();
    for (int i = 0; i < 4; i++) set_op(i, KM);
    in_vld = 1;
    step("R1 reset with bundle present");
    step("R1 reset second cycle");
    rst = 0;
    clear_bundle();
    step("R2 idle after reset");

    clear_bundle(); in_vld = 1;
    for (int i = 0; i < 4; i++) set_op(i, KM);
    step("R3 four multiply-adds");
    set_mfu(3'd0);
    step("R8 four multiply-adds with extra mfu");
    clear_bundle();
    step("R2 idle clears error");

    clear_bundle(); in_vld = 1;
    set_op(0, KD2); set_op(1, KD2);
    for (int c = 0; c < 6; c++) begin
      set_mfu(3'(c));
      step("R4 R7 R10 two dp2 with mfu code");
    end
    set_mfu(3'd6); step("R7 mfu code 6 illegal");
    set_mfu(3'd7); step("R7 mfu code 7 illegal");
    mfu_vld = 0;   step("R8 two dp2 missing mfu");

    clear_bundle(); in_vld = 1; set_mfu(3'd4);
    set_op(0, KD3); set_op(1, KM);
    step("R5 R10 dp3 then mad");
    clear_bundle(); in_vld = 1; set_mfu(3'd4);
    set_op(0, KM); set_op(1, KD3);
    step("R5 mad then dp3 illegal");

    clear_bundle(); in_vld = 1; set_mfu(3'd1);
    set_op(0, KD2); set_op(1, KM); set_op(2, KM);
    step("R6 dp2 at lane 0");
    clear_bundle(); in_vld = 1; set_mfu(3'd1);
    set_op(0, KM); set_op(2, KM); set_op(3, KD2);
    step("R6 dp2 at lane 2 with slot gap");
    clear_bundle(); in_vld = 1; set_mfu(3'd1);
    set_op(0, KM); set_op(1, KD2); set_op(2, KM);
    step("R6 dp2 at odd lane illegal");

    clear_bundle(); in_vld = 1; set_mfu(3'd2);
    set_op(0, KD2); set_op(1, KR);
    step("R8 reserved kind");
    clear_bundle(); in_vld = 1; set_mfu(3'd2);
    set_op(0, KD3); set_op(1, KD3);
    step("R8 lane demand over four");
    clear_bundle(); in_vld = 1; set_mfu(3'd2);
    set_op(0, KD2); set_op(1, KD2); set_op(2, KM);
    step("R8 five lanes");
    clear_bundle(); in_vld = 1;
    step("R8 empty bundle");

    clear_bundle(); in_vld = 1; set_mfu(3'd3);
    set_op(0, KD2); set_op(1, KD2);
    step("R4 before stall");
    stall = 1;
    clear_bundle(); in_vld = 1;
    for (int i = 0; i < 4; i++) set_op(i, KM);
    step("R9 stall holds issue");
    clear_bundle();
    step("R9 stall ignores idle");
    stall = 0;
    in_vld = 1; set_op(0, KR);
    step("R8 error before stall");
    stall = 1; clear_bundle();
    step("R9 stall holds error");
    stall = 0;
    step("R2 idle after stall");

    for (int n = 0; n < 400; n++) begin
      random_bundle();
      stall = ($urandom % 5) == 0;
      step("R3 R4 R5 R6 R7 R8 R9 random");
    end
    stall = 0; clear_bundle();
    step("R2 final idle");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule